// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The block takes one memory request from a 32-lane warp, in which every lane that is marked valid names the byte address of one 4-byte word. It groups the active lanes by the aligned memory segment their word falls in and issues one bus transaction per distinct segment. Each transaction carries the segment base address, its size and the mask of lanes it serves. A mode pin picks the segment size. In line mode a transaction moves a 128-byte line. In sector mode it moves a 32-byte sector.

Requests enter on a valid/ready handshake. `in_ready` is high only while no transaction of the previous request is still waiting. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Transactions leave on a second valid/ready handshake. `tx_valid` stays high and the transaction fields stay fixed until `tx_ready` is seen high at a clock edge. One transaction completes per cycle while `tx_ready` is held high. The cycle after a request finishes, a one-cycle `done` pulse reports three figures: the transaction count, the useful bytes (four per active lane) and the moved bytes (the sum of the segment sizes issued). Utilisation is the ratio of the last two.

Top module: `warp_coalescer`

## Requirements
- R1: Only lanes whose bit in `in_lane_valid` is 1 are served. The address of a lane whose bit is 0 creates no transaction and appears in no lane mask.
- R2: The number of transactions for one request equals the number of distinct aligned segments holding the words of the active lanes. Every transaction has a non-empty lane mask.
- R3: With `in_line_mode` = 1 the segment is a 128-byte line. `tx_addr` is a multiple of 128 and `tx_bytes` is 128.
- R4: With `in_line_mode` = 0 the segment is a 32-byte sector. `tx_addr` is a multiple of 32 and `tx_bytes` is 32.
- R5: The transactions of one request are issued in strictly ascending `tx_addr` order.
- R6: The `tx_lanes` masks of one request are pairwise disjoint and together equal the accepted `in_lane_valid`. Every lane set in `tx_lanes` has its address inside [`tx_addr`, `tx_addr`+`tx_bytes`).
- R7: While `tx_valid` is 1 and `tx_ready` is 0, the next cycle keeps `tx_valid`, `tx_addr` and `tx_lanes` unchanged. With `tx_ready` held at 1, a new transaction is issued every cycle. `tx_last` is 1 on the final transaction of a request.
- R8: `in_ready` is 0 while any transaction of the current request is pending. `in_valid` asserted in that time has no effect on the transactions or results of that request.
- R9: A request with no valid lanes issues no transaction. It produces `done` on the cycle after acceptance, with all three counts at zero.
- R10: `done` pulses for one cycle after the last transaction is handed over. At that time `done_tx_count` is the number of transactions, `done_useful_bytes` is 4 times the number of active lanes, and `done_moved_bytes` is the sum of the `tx_bytes` values issued.
- R11: After reset `in_ready` is 1, and `tx_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Warp request offered |
| in_ready | output | 1 | Block can accept a request |
| in_line_mode | input | 1 | 1: 128-byte lines, 0: 32-byte sectors |
| in_lane_valid | input | 32 | Active lane mask |
| in_lane_addr | input | 1024 | Byte address of lane i in bits [32i+31:32i] |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_addr | output | 32 | Aligned segment base address |
| tx_bytes | output | 8 | Segment size in bytes |
| tx_lanes | output | 32 | Lanes served by this transaction |
| tx_last | output | 1 | Final transaction of the request |
| done | output | 1 | One-cycle pulse when a request is finished |
| done_tx_count | output | 6 | Transactions issued for the request |
| done_useful_bytes | output | 8 | Bytes the active lanes asked for |
| done_moved_bytes | output | 13 | Bytes moved across the bus |

## Verification
The bench targets the following corner cases:
- A 32-word run that straddles a line boundary must give two transactions. A design that fails to merge lanes by segment would give 32.
- A descending address pattern must still come out in ascending order. A design that issues transactions in lane order would reverse it.
- A sector-mode run that starts mid-sector must give five transactions and 160 moved bytes. A design that gets the alignment mask wrong would miscount here.
- An empty request must finish at once. A design that treats it as a normal request would hang or report non-zero counts.
- Inactive lanes are given addresses in a separate line. A design that consults them would emit a spurious transaction.
- `tx_ready` is held low while `in_valid` is offered again. A design that re-accepts too early would corrupt the pending lane set.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int WORD_BYTES = 4;

  typedef enum logic {
    MODE_SECTOR = 1'b0,
    MODE_LINE   = 1'b1
  } seg_mode_e;
endpackage

// File: rtl/coal_seg_min.sv
// Finds the lowest segment base among pending lanes with a balanced
// comparison tree (LANES must be a power of two).
module coal_seg_min #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [ADDR_W-1:0]       base_mask,
  output logic                    any_pending,
  output logic [ADDR_W-1:0]       min_base
);
  localparam int NODES = 2*LANES - 1;

  logic              node_v [NODES];
  logic [ADDR_W-1:0] node_a [NODES];

  for (genvar i = 0; i < LANES; i++) begin : g_leaf
    assign node_v[LANES-1+i] = pending[i];
    assign node_a[LANES-1+i] = lane_addr[i*ADDR_W +: ADDR_W] & base_mask;
  end

  for (genvar k = 0; k < LANES-1; k++) begin : g_node
    logic take_right;
    assign take_right = node_v[2*k+2] &&
                        (!node_v[2*k+1] || (node_a[2*k+2] < node_a[2*k+1]));
    assign node_v[k]  = node_v[2*k+1] | node_v[2*k+2];
    assign node_a[k]  = take_right ? node_a[2*k+2] : node_a[2*k+1];
  end

  assign any_pending = node_v[0];
  assign min_base    = node_a[0];
endmodule

// File: rtl/coal_lane_match.sv
// Marks every pending lane whose segment equals the selected base.
module coal_lane_match #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [ADDR_W-1:0]       base_mask,
  input  logic [ADDR_W-1:0]       sel_base,
  output logic [LANES-1:0]        hit
);
  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign hit[i] = pending[i] &&
                    ((lane_addr[i*ADDR_W +: ADDR_W] & base_mask) == sel_base);
  end
endmodule

// File: rtl/coal_stats.sv
// Per-request counters and the completion pulse.
module coal_stats
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [LANES-1:0]        accept_mask,
  input  logic                    handoff,
  input  logic                    handoff_last,
  input  logic [$clog2(LINE_BYTES+1)-1:0] seg_bytes,
  output logic                    done,
  output logic [$clog2(LANES+1)-1:0]                   tx_count,
  output logic [$clog2(LANES*WORD_BYTES+1)-1:0]        useful_bytes,
  output logic [$clog2(LANES*LINE_BYTES+1)-1:0]        moved_bytes
);
  localparam int CNT_W = $clog2(LANES+1);
  localparam int USE_W = $clog2(LANES*WORD_BYTES+1);
  localparam int MOV_W = $clog2(LANES*LINE_BYTES+1);

  logic [CNT_W-1:0] active_lanes;

  always_comb begin
    active_lanes = '0;
    for (int i = 0; i < LANES; i++) begin
      active_lanes = active_lanes + CNT_W'(accept_mask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      tx_count     <= '0;
      useful_bytes <= '0;
      moved_bytes  <= '0;
    end else if (accept) begin
      done         <= (accept_mask == '0);
      tx_count     <= '0;
      useful_bytes <= USE_W'(active_lanes) * USE_W'(WORD_BYTES);
      moved_bytes  <= '0;
    end else if (handoff) begin
      done         <= handoff_last;
      tx_count     <= tx_count + 1'b1;
      moved_bytes  <= moved_bytes + MOV_W'(seg_bytes);
    end else begin
      done         <= 1'b0;
    end
  end

  // R9: an empty request finishes on the next cycle with nothing issued
  assert_empty_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accept_mask == '0) |=> (done && tx_count == '0 && moved_bytes == '0));

  // R10: the pulse lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done);
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_line_mode,
  input  logic [LANES-1:0]        in_lane_valid,
  input  logic [LANES*ADDR_W-1:0] in_lane_addr,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [ADDR_W-1:0]       tx_addr,
  output logic [$clog2(LINE_BYTES+1)-1:0] tx_bytes,
  output logic [LANES-1:0]        tx_lanes,
  output logic                    tx_last,
  output logic                    done,
  output logic [$clog2(LANES+1)-1:0]                 done_tx_count,
  output logic [$clog2(LANES*WORD_BYTES+1)-1:0]      done_useful_bytes,
  output logic [$clog2(LANES*LINE_BYTES+1)-1:0]      done_moved_bytes
);
  localparam int SZ_W     = $clog2(LINE_BYTES+1);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int SECT_LSB = $clog2(SECTOR_BYTES);

  logic [LANES-1:0]        pending_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  seg_mode_e               mode_q;
  logic [ADDR_W-1:0]       base_mask;
  logic                    any_pending;
  logic                    accept;
  logic                    handoff;

  assign base_mask = (mode_q == MODE_LINE) ? ~ADDR_W'(LINE_BYTES-1)
                                           : ~ADDR_W'(SECTOR_BYTES-1);
  assign tx_bytes  = (mode_q == MODE_LINE) ? SZ_W'(LINE_BYTES)
                                           : SZ_W'(SECTOR_BYTES);

  coal_seg_min #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min (
    .pending     (pending_q),
    .lane_addr   (addr_q),
    .base_mask   (base_mask),
    .any_pending (any_pending),
    .min_base    (tx_addr)
  );

  coal_lane_match #(.LANES(LANES), .ADDR_W(ADDR_W)) u_match (
    .pending   (pending_q),
    .lane_addr (addr_q),
    .base_mask (base_mask),
    .sel_base  (tx_addr),
    .hit       (tx_lanes)
  );

  assign tx_valid = any_pending;
  assign tx_last  = any_pending && ((pending_q & ~tx_lanes) == '0);
  assign in_ready = !any_pending;
  assign accept   = in_valid && in_ready;
  assign handoff  = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
      addr_q    <= '0;
      mode_q    <= MODE_SECTOR;
    end else if (accept) begin
      pending_q <= in_lane_valid;
      addr_q    <= in_lane_addr;
      mode_q    <= seg_mode_e'(in_line_mode);
    end else if (handoff) begin
      pending_q <= pending_q & ~tx_lanes;
    end
  end

  coal_stats #(.LANES(LANES), .LINE_BYTES(LINE_BYTES)) u_stats (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .accept_mask  (in_lane_valid),
    .handoff      (handoff),
    .handoff_last (tx_last),
    .seg_bytes    (tx_bytes),
    .done         (done),
    .tx_count     (done_tx_count),
    .useful_bytes (done_useful_bytes),
    .moved_bytes  (done_moved_bytes)
  );

  // R2: an offered transaction always serves someone
  assert_lanes_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_lanes != '0);

  // R3: line mode keeps line alignment
  assert_line_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && mode_q == MODE_LINE) |-> tx_addr[LINE_LSB-1:0] == '0);

  // R4: sector mode keeps sector alignment
  assert_sector_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && mode_q == MODE_SECTOR) |-> tx_addr[SECT_LSB-1:0] == '0);

  // R5: addresses rise within one request
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff && !tx_last) |=> (tx_valid && tx_addr > $past(tx_addr)));

  // R6: consecutive masks never share a lane
  assert_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff && !tx_last) |=> ((tx_lanes & $past(tx_lanes)) == '0));

  // R7: a stalled transaction holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_addr) && $stable(tx_lanes)));

  // R10: completion only after the stream has drained
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid);
endmodule

// File: tb/test_warp_coalescer.sv
`timescale 1ns/1ps
module test_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;

  typedef struct packed {
    logic        line;
    logic [31:0] base;
    logic [31:0] stride;
    logic [31:0] mask;
    logic        stall;
    logic [5:0]  exp_tx;
    logic [7:0]  exp_useful;
    logic [12:0] exp_moved;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0000, 32'd4,        32'hFFFF_FFFF, 1'b0, 6'd1,  8'd128, 13'd128},
    '{1'b1, 32'h0000_0040, 32'd4,        32'hFFFF_FFFF, 1'b0, 6'd2,  8'd128, 13'd256},
    '{1'b0, 32'h0000_0000, 32'd4,        32'hFFFF_FFFF, 1'b1, 6'd4,  8'd128, 13'd128},
    '{1'b0, 32'h0000_0010, 32'd4,        32'hFFFF_FFFF, 1'b0, 6'd5,  8'd128, 13'd160},
    '{1'b0, 32'h0000_0300, 32'd4,        32'h0000_0001, 1'b0, 6'd1,  8'd4,   13'd32},
    '{1'b1, 32'h0000_0300, 32'd4,        32'h0000_0001, 1'b0, 6'd1,  8'd4,   13'd128},
    '{1'b1, 32'h0000_0000, 32'd128,      32'hFFFF_FFFF, 1'b1, 6'd32, 8'd128, 13'd4096},
    '{1'b1, 32'h0000_5000, 32'hFFFF_FF80, 32'hFFFF_FFFF, 1'b0, 6'd32, 8'd128, 13'd4096},
    '{1'b1, 32'h0000_0000, 32'd64,       32'h5555_5555, 1'b0, 6'd16, 8'd64,  13'd2048},
    '{1'b1, 32'h0000_0080, 32'd0,        32'hFFFF_FFFF, 1'b0, 6'd1,  8'd128, 13'd128},
    '{1'b0, 32'h0000_0000, 32'd4,        32'h0000_0000, 1'b0, 6'd0,  8'd0,   13'd0},
    '{1'b0, 32'h0000_1000, 32'd8,        32'hFFFF_FFFF, 1'b0, 6'd8,  8'd128, 13'd256}
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic                 in_ready;
  logic                 in_line_mode;
  logic [LANES-1:0]     in_lane_valid;
  logic [LANES*AW-1:0]  in_lane_addr;
  logic                 tx_valid;
  logic                 tx_ready;
  logic [AW-1:0]        tx_addr;
  logic [7:0]           tx_bytes;
  logic [LANES-1:0]     tx_lanes;
  logic                 tx_last;
  logic                 done;
  logic [5:0]           done_tx_count;
  logic [7:0]           done_useful_bytes;
  logic [12:0]          done_moved_bytes;

  int tests = 0;
  int fails = 0;
  logic finished = 1'b0;
  logic [31:0] lane_a [LANES];

  always #4 clk = ~clk;

  warp_coalescer i_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line_mode(in_line_mode), .in_lane_valid(in_lane_valid),
    .in_lane_addr(in_lane_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_addr(tx_addr), .tx_bytes(tx_bytes), .tx_lanes(tx_lanes),
    .tx_last(tx_last), .done(done), .done_tx_count(done_tx_count),
    .done_useful_bytes(done_useful_bytes), .done_moved_bytes(done_moved_bytes)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic line, input logic [31:0] mask);
    @(negedge clk);
    chk(in_ready, "R8", "idle in_ready", 64'(in_ready), 64'd1);
    in_valid      = 1'b1;
    in_line_mode  = line;
    in_lane_valid = mask;
    for (int i = 0; i < LANES; i++) in_lane_addr[i*AW +: AW] = lane_a[i];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Walks the transaction stream of one request and checks it.
  task automatic collect(input logic line, input logic [31:0] mask,
                         input logic stall, input int exp_tx,
                         input int exp_useful, input int exp_moved);
    logic [31:0] seen = '0;
    logic [31:0] prev_addr = '0;
    logic        have_prev = 1'b0;
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    logic [31:0] held_lanes = '0;
    int          ntx = 0;
    int          moved = 0;
    logic [7:0]  sz = line ? 8'd128 : 8'd32;
    bit          ok_lanes;
    for (int cyc = 0; cyc < 400; cyc++) begin
      tx_ready = stall ? cyc[0] : 1'b1;
      #1;
      if (done) begin
        chk(done_tx_count == 6'(exp_tx), "R2", "tx count", 64'(done_tx_count), 64'(exp_tx));
        chk(seen == mask, "R6", "lane union", 64'(seen), 64'(mask));
        chk(done_useful_bytes == 8'(exp_useful), "R10", "useful bytes",
            64'(done_useful_bytes), 64'(exp_useful));
        chk(done_moved_bytes == 13'(exp_moved) && moved == exp_moved, "R10", "moved bytes",
            64'(done_moved_bytes), 64'(exp_moved));
        chk(ntx == exp_tx, "R2", "observed tx", 64'(ntx), 64'(exp_tx));
        @(negedge clk);
        chk(!done && in_ready, "R10", "pulse ends, ready back", 64'({done, in_ready}), 64'b01);
        return;
      end
      if (held) begin
        chk(tx_valid && tx_addr == held_addr && tx_lanes == held_lanes, "R7", "hold under stall",
            64'(tx_addr), 64'(held_addr));
      end
      held = 1'b0;
      if (tx_valid) begin
        if (in_ready) chk(1'b0, "R8", "in_ready while busy", 64'(in_ready), 64'd0);
        if (!tx_ready) begin
          held = 1'b1; held_addr = tx_addr; held_lanes = tx_lanes;
        end else begin
          ntx++;
          moved += int'(tx_bytes);
          chk(tx_bytes == sz && (tx_addr & 32'(sz - 1)) == 0, line ? "R3" : "R4",
              "segment size/alignment", 64'(tx_addr), 64'(sz));
          if (have_prev) chk(tx_addr > prev_addr, "R5", "ascending", 64'(tx_addr), 64'(prev_addr));
          chk((tx_lanes & seen) == '0 && (tx_lanes & ~mask) == '0 && tx_lanes != '0, "R6",
              "disjoint masks within valid", 64'(tx_lanes), 64'(mask));
          ok_lanes = 1;
          for (int i = 0; i < LANES; i++)
            if (tx_lanes[i] && ((lane_a[i] & ~32'(sz - 1)) != tx_addr)) ok_lanes = 0;
          chk(ok_lanes, "R6", "lane inside segment", 64'(tx_lanes), 64'(tx_addr));
          chk(tx_last == ((seen | tx_lanes) == mask), "R7", "last flag", 64'(tx_last),
              64'((seen | tx_lanes) == mask));
          seen = seen | tx_lanes;
          prev_addr = tx_addr;
          have_prev = 1'b1;
        end
      end
      @(negedge clk);
    end
    chk(1'b0, "R10", "no done seen", 64'd0, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_line_mode = 1'b0; in_lane_valid = '0;
    in_lane_addr = '0; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(in_ready && !tx_valid && !done, "R11", "reset state",
        64'({in_ready, tx_valid, done}), 64'b100);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < LANES; i++) lane_a[i] = VECS[v].base + 32'(i) * VECS[v].stride;
      issue(VECS[v].line, VECS[v].mask);
      collect(VECS[v].line, VECS[v].mask, VECS[v].stall, int'(VECS[v].exp_tx),
              int'(VECS[v].exp_useful), int'(VECS[v].exp_moved));
    end

    // R1: inactive lane points at a different line and must be ignored
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h0000_1000 + 32'(i) * 4;
    lane_a[0] = 32'h0000_0000;
    issue(1'b1, 32'hFFFF_FFFE);
    collect(1'b1, 32'hFFFF_FFFE, 1'b0, 1, 124, 128);

    // R8: a second request offered while stalled has no effect
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h0000_0200 + 32'(i) * 4;
    issue(1'b1, 32'hFFFF_FFFF);
    tx_ready = 1'b0;
    in_valid = 1'b1;
    in_line_mode = 1'b0;
    in_lane_valid = 32'h0000_000F;
    for (int i = 0; i < LANES; i++) in_lane_addr[i*AW +: AW] = 32'h0009_0000 + 32'(i) * 256;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    collect(1'b1, 32'hFFFF_FFFF, 1'b0, 1, 128, 128);
    chk(!tx_valid, "R8", "no extra request taken", 64'(tx_valid), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule